// File: doc/BRIEF.md
# Flash Status Polling Read Unit

This unit produces the read data word of a parallel NOR flash controller that follows the classic unlock-and-command protocol. The controller's command decoder reports the current operating mode. For each read, the unit chooses between three sources: array data passed through from storage, identification words in autoselect mode, or an 8-bit status byte. Host software polls that status byte to learn whether a program or erase is still in progress.

The status byte changes from read to read. Bit 6 flips on every status read while a program or erase is pending. Bit 2 flips only when the operation is an erase. While an erase is suspended, reads of sectors queued for erase still see status, and all other sectors return array data. Bits 7 and 3 are not changed by reads. The decoder moves them with single-cycle event strobes: program load, erase start, erase timeout expiry and operation completion.

The returned word is combinational from the inputs and the held status byte. The status updates caused by a read, and by any event strobe, land on the rising clock edge at the end of that cycle.

Top module: `flash_status_read`

## Requirements
- R1: After an asynchronous active-low reset the status byte is 0x00, so the first program-mode read returns 0x0040.
- R2: Mode codes are 0 = array read, 1 = autoselect, 2 = program, 3 = sector erase, 4 = chip erase; codes 5 to 7 behave as code 0. In code 0 without a suspended-and-marked access, `rd_data` equals `arr_data` and the status byte is unchanged.
- R3: In mode 2 each read returns the status byte with bit 6 inverted, and that inversion is stored at the clock edge; bit 2 is not changed.
- R4: In modes 3 and 4 each read returns the status byte with bits 6 and 2 inverted, and both inversions are stored at the clock edge.
- R5: In mode 0 (or 5 to 7) with `suspend` high, a read with `sect_marked` high returns the status byte with only bit 2 inverted, and stores that inversion. With `sect_marked` low it returns `arr_data`.
- R6: `prog_load` sets status bit 7 to the complement of `prog_msb`.
- R7: `erase_start` clears status bits 7 and 3.
- R8: `erase_go` sets bit 3, and `op_done` inverts bit 7 and clears bit 3. Priority, highest first: for bit 7, `erase_start`, then `prog_load`, then `op_done`; for bit 3, `erase_start` and `op_done` (both clear), then `erase_go`.
- R9: In mode 1, word index 0 returns ID0, index 1 returns ID1 and index 2 returns zero.
- R10: In mode 1, indexes 0x0E and 0x0F return ID2 and ID3, unless the selected value is all ones, in which case `arr_data` is returned. All other indexes return `arr_data`.
- R11: The word index is `rd_addr[7:0]` shifted right by 0, 1 or 2 for DATA_BYTES of 1, 2 or 4; the lower byte-offset bits are ignored.
- R12: A status word carries the byte in bits 7:0 with zeros above. Cycles with `rd_en` low change no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe; applies this read's status toggles at the clock edge |
| rd_addr | input | ADDR_W | Byte offset of the read |
| mode | input | 3 | Command state from the decoder |
| arr_data | input | 8*DATA_BYTES | Array data at `rd_addr` |
| suspend | input | 1 | Erase is suspended |
| sect_marked | input | 1 | Addressed sector is queued for erase |
| prog_load | input | 1 | Program data accepted this cycle |
| prog_msb | input | 1 | Bit 7 of the data being programmed |
| erase_start | input | 1 | An erase command was accepted |
| erase_go | input | 1 | Sector queueing window closed, erase running |
| op_done | input | 1 | Program or erase finished |
| rd_data | output | 8*DATA_BYTES | Returned read word |

## Verification
A corrupted status register only becomes visible on the next status read, which is usually the following cycle in a polling stream. It shows as bit 6 or bit 2 being out of phase, or as bit 7 or bit 3 disagreeing with the last event. The bench therefore mixes long random streams of reads and event strobes with a reference status byte. It compares every read word, so a single missed or extra toggle makes every later status read in that mode miscompare. Autoselect index decoding and the fallback to array data for an all-ones identifier are checked at chosen offsets, including offsets whose ignored low bits are set.

// File: rtl/flash_status_read.sv
module flash_status_read #(
  parameter int DATA_BYTES = 2,
  parameter int ADDR_W = 20,
  parameter int IDENT_W = 16,
  parameter logic [IDENT_W-1:0] ID0 = 16'h0001,
  parameter logic [IDENT_W-1:0] ID1 = 16'h227E,
  parameter logic [IDENT_W-1:0] ID2 = 16'h2210,
  parameter logic [IDENT_W-1:0] ID3 = 16'h2201
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         rd_addr,
  input  logic [2:0]                mode,
  input  logic [8*DATA_BYTES-1:0]   arr_data,
  input  logic                      suspend,
  input  logic                      sect_marked,
  input  logic                      prog_load,
  input  logic                      prog_msb,
  input  logic                      erase_start,
  input  logic                      erase_go,
  input  logic                      op_done,
  output logic [8*DATA_BYTES-1:0]   rd_data
);
  localparam int DW = 8 * DATA_BYTES;
  localparam int SHIFT = (DATA_BYTES == 4) ? 2 : (DATA_BYTES == 2) ? 1 : 0;
  localparam logic [2:0] M_AUTO = 3'd1, M_PROG = 3'd2, M_SERASE = 3'd3, M_CERASE = 3'd4;

  function automatic logic [DW-1:0] fit(input logic [IDENT_W-1:0] v);
    logic [DW+IDENT_W-1:0] wide;
    wide = {{DW{1'b0}}, v};
    return wide[DW-1:0];
  endfunction

  logic [7:0]    stat_q, stat_d, tog;
  logic          use_stat;
  logic [7:0]    idx;
  logic [DW-1:0] auto_word;

  assign idx = rd_addr[7:0] >> SHIFT;

  always_comb begin
    tog = 8'h00;
    use_stat = 1'b0;
    case (mode)
      M_PROG: begin use_stat = 1'b1; tog = 8'h40; end
      M_SERASE, M_CERASE: begin use_stat = 1'b1; tog = 8'h44; end
      M_AUTO: ;
      default: if (suspend && sect_marked) begin use_stat = 1'b1; tog = 8'h04; end
    endcase
  end

  always_comb begin
    case (idx)
      8'h00: auto_word = fit(ID0);
      8'h01: auto_word = fit(ID1);
      8'h02: auto_word = '0;
      8'h0E: auto_word = (&ID2) ? arr_data : fit(ID2);
      8'h0F: auto_word = (&ID3) ? arr_data : fit(ID3);
      default: auto_word = arr_data;
    endcase
  end

  assign rd_data = use_stat ? {{(DW-8){1'b0}}, stat_q ^ tog}
                 : (mode == M_AUTO) ? auto_word : arr_data;

  always_comb begin
    stat_d = stat_q ^ (rd_en ? tog : 8'h00);
    if (erase_go) stat_d[3] = 1'b1;
    if (op_done) begin
      stat_d[7] = ~stat_q[7];
      stat_d[3] = 1'b0;
    end
    if (prog_load) stat_d[7] = ~prog_msb;
    if (erase_start) begin
      stat_d[7] = 1'b0;
      stat_d[3] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stat_q <= 8'h00;
    else        stat_q <= stat_d;
endmodule

// File: rtl/flash_status_read_chk.sv
module flash_status_read_chk #(
  parameter int DATA_BYTES = 2,
  parameter int ADDR_W = 20
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    rd_en,
  input logic [ADDR_W-1:0]       rd_addr,
  input logic [2:0]              mode,
  input logic                    suspend,
  input logic                    sect_marked,
  input logic                    prog_load,
  input logic                    erase_start,
  input logic                    erase_go,
  input logic                    op_done,
  input logic [8*DATA_BYTES-1:0] rd_data,
  input logic [7:0]              stat_q
);
  logic quiet, stat_mode, plain_rd;
  assign quiet = !prog_load && !erase_start && !erase_go && !op_done;
  assign stat_mode = (mode == 3'd2) || (mode == 3'd3) || (mode == 3'd4);
  assign plain_rd = (mode == 3'd0) || (mode > 3'd4);

  // R3
  prog_bit6_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mode == 3'd2 && quiet) |=>
      (stat_q[6] != $past(stat_q[6])) && (stat_q[2] == $past(stat_q[2])));

  // R4
  erase_bits_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (mode == 3'd3 || mode == 3'd4) && quiet) |=>
      (stat_q[6] != $past(stat_q[6])) && (stat_q[2] != $past(stat_q[2])));

  // R5
  susp_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && plain_rd && suspend && sect_marked && quiet) |=>
      (stat_q[2] != $past(stat_q[2])) && $stable(stat_q[6]));

  // R7
  erase_start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> (stat_q[7] == 1'b0) && (stat_q[3] == 1'b0));

  // R8
  erase_go_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_go && !erase_start && !op_done) |=> stat_q[3]);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && quiet) |=> $stable(stat_q));

  // R12
  status_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && stat_mode) |-> ((rd_data >> 8) == '0));
endmodule

bind flash_status_read flash_status_read_chk #(.DATA_BYTES(DATA_BYTES), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .mode(mode),
  .suspend(suspend), .sect_marked(sect_marked), .prog_load(prog_load),
  .erase_start(erase_start), .erase_go(erase_go), .op_done(op_done),
  .rd_data(rd_data), .stat_q(stat_q)
);

// File: tb/flash_status_read_tb_top.sv
module flash_status_read_tb_top;
  localparam int CLK_NS = 10;
  localparam int AW = 20;
  localparam logic [15:0] I0 = 16'h0001, I1 = 16'h227E, I2 = 16'h2210, I3 = 16'hFFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_en = 0, suspend = 0, sect_marked = 0, prog_load = 0, prog_msb = 0;
  logic erase_start = 0, erase_go = 0, op_done = 0;
  logic [AW-1:0] rd_addr = '0;
  logic [2:0] mode = '0;
  logic [15:0] arr_data = '0, rd_data;

  always #(CLK_NS/2) clk = ~clk;

  flash_status_read #(.DATA_BYTES(2), .ADDR_W(AW), .IDENT_W(16),
    .ID0(I0), .ID1(I1), .ID2(I2), .ID3(I3)) dut_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .mode(mode),
    .arr_data(arr_data), .suspend(suspend), .sect_marked(sect_marked),
    .prog_load(prog_load), .prog_msb(prog_msb), .erase_start(erase_start),
    .erase_go(erase_go), .op_done(op_done), .rd_data(rd_data));

  int vecs = 0, fails = 0;
  logic [7:0] st_m = 8'h00;
  string pend = "";
  bit finished = 0;

  function automatic logic [7:0] tmask(input logic [2:0] m, input logic s, input logic mk);
    case (m)
      3'd2: return 8'h40;
      3'd3, 3'd4: return 8'h44;
      3'd1: return 8'h00;
      default: return (s && mk) ? 8'h04 : 8'h00;
    endcase
  endfunction

  function automatic logic is_stat(input logic [2:0] m, input logic s, input logic mk);
    return (m == 3'd2 || m == 3'd3 || m == 3'd4) || (m != 3'd1 && s && mk);
  endfunction

  function automatic logic [15:0] auto_val(input logic [7:0] ix, input logic [15:0] d);
    case (ix)
      8'h00: return I0;
      8'h01: return I1;
      8'h02: return 16'h0000;
      8'h0E: return (I2 == 16'hFFFF) ? d : I2;
      8'h0F: return (I3 == 16'hFFFF) ? d : I3;
      default: return d;
    endcase
  endfunction

  task automatic step(input logic r, input logic [AW-1:0] a, input logic [2:0] m,
                      input logic [15:0] d, input logic s, input logic mk,
                      input logic pl, input logic pb, input logic es,
                      input logic eg, input logic od, input string tag_in);
    logic [15:0] exp;
    logic [7:0] ix, nxt;
    string tag;
    @(negedge clk);
    rd_en = r; rd_addr = a; mode = m; arr_data = d; suspend = s; sect_marked = mk;
    prog_load = pl; prog_msb = pb; erase_start = es; erase_go = eg; op_done = od;
    #1;
    ix = a[7:0] >> 1;
    if (is_stat(m, s, mk)) exp = {8'h00, st_m ^ tmask(m, s, mk)};
    else if (m == 3'd1) exp = auto_val(ix, d);
    else exp = d;
    if (r) begin
      if (tag_in != "") tag = tag_in;
      else if (is_stat(m, s, mk) && pend != "") tag = pend;
      else if (m == 3'd2) tag = "R3";
      else if (m == 3'd3 || m == 3'd4) tag = "R4";
      else if (m == 3'd1) tag = (ix <= 8'h02) ? "R9" : (ix == 8'h0E || ix == 8'h0F) ? "R10" : "R11";
      else if (s && mk) tag = "R5";
      else tag = "R2";
      if (is_stat(m, s, mk)) pend = "";
      vecs++;
      if (rd_data !== exp) begin
        fails++;
        $display("FAIL %s: mode=%0d addr=%h got %h expected %h", tag, m, a, rd_data, exp);
      end
    end
    nxt = st_m ^ (r ? tmask(m, s, mk) : 8'h00);
    if (eg) nxt[3] = 1'b1;
    if (od) begin nxt[7] = ~st_m[7]; nxt[3] = 1'b0; end
    if (pl) nxt[7] = ~pb;
    if (es) begin nxt[7] = 1'b0; nxt[3] = 1'b0; end
    st_m = nxt;
    if (es) pend = "R7"; else if (pl) pend = "R6"; else if (od || eg) pend = "R8";
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset value seen through first program status read
    step(1, '0, 3'd2, 16'hBEEF, 0, 0, 0, 0, 0, 0, 0, "R1");
    // R12: idle cycles in program mode leave status untouched
    for (int i = 0; i < 3; i++) step(0, '0, 3'd2, 16'h1234, 0, 0, 0, 0, 0, 0, 0, "R12");
    step(1, '0, 3'd2, 16'h1234, 0, 0, 0, 0, 0, 0, 0, "R12");
    // R6 / R7 / R8 event sequence
    step(0, '0, 3'd0, 16'h0, 0, 0, 1, 0, 0, 0, 0, "");
    step(1, '0, 3'd2, 16'h0, 0, 0, 0, 0, 0, 0, 0, "R6");
    step(0, '0, 3'd0, 16'h0, 0, 0, 1, 1, 1, 0, 0, "");
    step(1, '0, 3'd3, 16'h0, 0, 0, 0, 0, 0, 0, 0, "R7");
    step(0, '0, 3'd3, 16'h0, 0, 0, 0, 0, 0, 1, 1, "");
    step(1, '0, 3'd3, 16'h0, 0, 0, 0, 0, 0, 0, 0, "R8");
    // R9, R10, R11: autoselect offsets including odd byte offsets
    step(1, 20'h00001, 3'd1, 16'hAAAA, 0, 0, 0, 0, 0, 0, 0, "R11");
    step(1, 20'h00003, 3'd1, 16'hAAAA, 0, 0, 0, 0, 0, 0, 0, "R11");
    step(1, 20'h00004, 3'd1, 16'hAAAA, 0, 0, 0, 0, 0, 0, 0, "R9");
    step(1, 20'h0001C, 3'd1, 16'hAAAA, 0, 0, 0, 0, 0, 0, 0, "R10");
    step(1, 20'h0001E, 3'd1, 16'h5A5A, 0, 0, 0, 0, 0, 0, 0, "R10");
    step(1, 20'h00100, 3'd1, 16'h3C3C, 0, 0, 0, 0, 0, 0, 0, "R11");
    // R2: undefined mode codes read the array
    step(1, 20'h00010, 3'd6, 16'h7777, 0, 0, 0, 0, 0, 0, 0, "R2");
    // R5: suspended erase, marked and unmarked sectors
    step(1, 20'h00020, 3'd0, 16'h9999, 1, 1, 0, 0, 0, 0, 0, "R5");
    step(1, 20'h00020, 3'd0, 16'h9999, 1, 0, 0, 0, 0, 0, 0, "R5");
    step(1, 20'h00020, 3'd5, 16'h9999, 1, 1, 0, 0, 0, 0, 0, "R5");
    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a;
      logic [2:0] m;
      int pick;
      a = AW'($urandom);
      if ($urandom_range(1, 0) == 1) begin
        pick = $urandom_range(5, 0);
        a[7:1] = (pick < 3) ? 7'(pick) : (pick == 3) ? 7'h0E : (pick == 4) ? 7'h0F : 7'h05;
      end
      m = 3'($urandom_range(7, 0));
      step($urandom_range(3, 0) != 0, a, m, 16'($urandom),
           $urandom_range(1, 0) == 1, $urandom_range(1, 0) == 1,
           $urandom_range(7, 0) == 0, $urandom_range(1, 0) == 1,
           $urandom_range(11, 0) == 0, $urandom_range(7, 0) == 0,
           $urandom_range(7, 0) == 0, "");
    end
    finished = 1;
    summary();
  end
endmodule